// File: doc/BRIEF.md
# Region-Based Bus Wait-State Generator

This block sits beside a CPU's memory bus and decides, for every read or write, how many extra cycles the access must last before the CPU may finish it. The 16-bit address is decoded into one of several regions (local RAM, three peripheral windows, flash, the flash key window, one-time-programmable memory, boot ROM). Each region has its own wait count. Some counts are fixed. Some depend on the direction of the access. Some come from software-set fields, which the block clamps to safe minimums. Flash accesses use a short count when they land in the same page as the previous flash access and a long count otherwise.

The CPU raises `rd` or `wr` and holds the address stable until it sees `rdy` high at a rising clock edge. An access with N wait states therefore completes in its (N+1)th cycle. Two peripheral windows can also be held off by an external ready line. One window adds a cycle between writes that follow each other with no gap. The decoded region is presented on `region` for the memory selects.

Top module: `bus_wait_gen`

## Requirements
- R1: Local RAM (0x0000-0x0FFF) and boot ROM (0xF000-0xFFFF) complete with 0 wait states, for reads and writes alike.
- R2: Peripheral window A (0x1000-0x1FFF) has 0 wait states and is further held off while `ext_rdy` is low. `rdy` never rises there while `ext_rdy` is low.
- R3: Peripheral windows B (0x2000-0x2FFF) and C (0x3000-0x3FFF) complete writes with 0 and reads with 2 wait states.
- R4: In window B, a write that starts in the cycle right after a window-B write completed takes 1 extra wait state. The penalty does not apply when an idle cycle separates the two writes, and it does not apply to a read.
- R5: Window C ignores `ext_rdy`. Its access ends after its fixed count even when `ext_rdy` is low.
- R6: Flash (0x4000-0x7FEF) uses the paged count when the access falls in the same 8-word page (address bits [15:3]) as the previous flash access. Otherwise it uses the random count. The first flash access after reset uses the random count.
- R7: The effective random count is the largest of `fl_rand_ws`, 1 and `fl_page_ws`. The effective paged count is `fl_page_ws`.
- R8: One-time-programmable memory (0x8000-0x8FFF) waits `otp_ws` cycles, with 0 raised to 1.
- R9: The flash key window (0x7FF0-0x7FFF) always waits 16 cycles, whatever the flash settings are. It does not change the remembered flash page.
- R10: `region` carries 1 RAM, 2 window A, 3 window B, 4 window C, 5 flash, 6 key window, 7 OTP, 8 boot ROM, and 0 for unmapped addresses (0x9000-0xEFFF).
- R11: `rdy` is low whenever neither `rd` nor `wr` is high, including right after reset.
- R12: With N wait states and no hold-off, `rdy` is low for the first N cycles of an access and high in cycle N+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 16 | Access address, held stable during the access |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| ext_rdy | input | 1 | Peripheral hold-off, active low, honoured by windows A and B |
| fl_page_ws | input | 4 | Programmed flash paged wait count |
| fl_rand_ws | input | 4 | Programmed flash random wait count |
| otp_ws | input | 4 | Programmed OTP wait count |
| rdy | output | 1 | Access completes at this rising edge |
| region | output | 4 | Decoded region code |

## Verification
The situations hardest to reach from the ports are the window-B write stall and the page memory of the flash path. Both depend on what the previous access was and on exactly when it ended. The bench issues window-B writes with no idle cycle between them, so a new write starts in the cycle after the previous `rdy`. It then repeats the writes with one idle cycle between them to show that the penalty goes away. For the page logic, flash addresses are ordered so that page hits, page misses and a key-window access come in between. The programmed fields are changed between accesses to drive the clamping corners.

// File: rtl/ws_pkg.sv
// Package: shared address map, region codes and fixed wait counts for the
// bus wait-state generator. Assumes a 16-bit word address bus.
package ws_pkg;
    parameter int AW        = 16;  // address width
    parameter int WS_W      = 4;   // width of a programmed wait field
    parameter int CW        = 5;   // width of the internal wait counter
    parameter int PAGE_BITS = 3;   // log2 of flash page size in words

    localparam int KEY_WS   = 16;  // flash key window fixed waits
    localparam int PER_RD_WS = 2;  // windows B/C read waits

    typedef enum logic [3:0] {
        RG_NONE  = 4'd0,
        RG_RAM   = 4'd1,
        RG_PERA  = 4'd2,
        RG_PERB  = 4'd3,
        RG_PERC  = 4'd4,
        RG_FLASH = 4'd5,
        RG_KEY   = 4'd6,
        RG_OTP   = 4'd7,
        RG_ROM   = 4'd8
    } region_e;
endpackage

// File: rtl/ws_region_decode.sv
// Module: ws_region_decode
// Maps an address onto a region code. Purely combinational.
// Assumes the 16-bit map of the package: top nibble selects the area and
// the last 16 words of the flash area form the key window.
module ws_region_decode
    import ws_pkg::*;
#(
    parameter int ADDR_W = AW
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region
);
    localparam int TOP = ADDR_W - 4;

    // Decode the area nibble, then split the key window out of flash.
    always_comb begin
        unique case (addr[ADDR_W-1:TOP])
            4'h0:                region = RG_RAM;
            4'h1:                region = RG_PERA;
            4'h2:                region = RG_PERB;
            4'h3:                region = RG_PERC;
            4'h4, 4'h5, 4'h6, 4'h7: begin
                if (addr[ADDR_W-1:4] == {4'h7, {(ADDR_W-8){1'b1}}})
                    region = RG_KEY;
                else
                    region = RG_FLASH;
            end
            4'h8:                region = RG_OTP;
            4'hF:                region = RG_ROM;
            default:             region = RG_NONE;
        endcase
    end
endmodule

// File: rtl/ws_count_select.sv
// Module: ws_count_select
// Chooses the wait count for the access that starts this cycle. It clamps
// the programmed fields and remembers the page of the last flash access.
// Assumes 'start' pulses for one cycle at the first cycle of each access.
module ws_count_select
    import ws_pkg::*;
#(
    parameter int ADDR_W = AW,
    parameter int FW     = WS_W,
    parameter int CNT_W  = CW,
    parameter int PG_B   = PAGE_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  region_e           region,
    input  logic              is_wr,
    input  logic              b2b_wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [FW-1:0]     page_ws,
    input  logic [FW-1:0]     rand_ws,
    input  logic [FW-1:0]     otp_ws,
    output logic [CNT_W-1:0]  wcount
);
    localparam int PGW = ADDR_W - PG_B;

    logic [PGW-1:0]   last_page_q;
    logic             page_vld_q;
    logic [CNT_W-1:0] page_eff, rand_min1, rand_eff, otp_eff;
    logic             same_page;

    // Clamp the programmed fields to their minimums.
    always_comb begin
        page_eff  = CNT_W'(page_ws);
        rand_min1 = (rand_ws == '0) ? CNT_W'(1) : CNT_W'(rand_ws);
        rand_eff  = (rand_min1 < page_eff) ? page_eff : rand_min1;
        otp_eff   = (otp_ws == '0) ? CNT_W'(1) : CNT_W'(otp_ws);
    end

    assign same_page = page_vld_q && (last_page_q == addr[ADDR_W-1:PG_B]);

    // Pick the wait count for the decoded region and direction.
    always_comb begin
        unique case (region)
            RG_PERB:  wcount = is_wr ? (b2b_wr ? CNT_W'(1) : '0)
                                     : CNT_W'(PER_RD_WS);
            RG_PERC:  wcount = is_wr ? '0 : CNT_W'(PER_RD_WS);
            RG_FLASH: wcount = same_page ? page_eff : rand_eff;
            RG_KEY:   wcount = CNT_W'(KEY_WS);
            RG_OTP:   wcount = otp_eff;
            default:  wcount = '0;
        endcase
    end

    // Remember the page of each flash access as it starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_page_q <= '0;
            page_vld_q  <= 1'b0;
        end else if (start && region == RG_FLASH) begin
            last_page_q <= addr[ADDR_W-1:PG_B];
            page_vld_q  <= 1'b1;
        end
    end

    assert_rand_floor_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rand_eff >= page_eff) && (rand_eff != '0));
    assert_otp_floor_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (region == RG_OTP) |-> (wcount != '0));
    assert_key_fixed_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (region == RG_KEY) |-> (wcount == CNT_W'(KEY_WS)));
endmodule

// File: rtl/ws_timer.sv
// Module: ws_timer
// Counts down the wait states of the current access and raises ready when
// the count is spent and the hold-off allows it. Assumes the requester
// keeps its strobe high until ready is seen at a rising edge.
module ws_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic [CNT_W-1:0] wcount,
    input  logic             hold_ok,
    output logic             start,
    output logic             rdy
);
    logic             busy_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] remaining;

    assign start     = req && !busy_q;
    assign remaining = busy_q ? cnt_q : wcount;
    assign rdy       = req && (remaining == '0) && hold_ok;

    // Load the count on the first cycle and step it down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (rdy || !req) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            busy_q <= 1'b1;
            cnt_q  <= (remaining == '0) ? '0 : remaining - 1'b1;
        end
    end

    assert_wait_blocks_rdy_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && cnt_q != '0) |-> !rdy);
    assert_count_steps_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && req && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1) || !req);
endmodule

// File: rtl/bus_wait_gen.sv
// Module: bus_wait_gen (top)
// Stretches each CPU bus access by the wait states of its region, applies
// the peripheral hold-off where the region honours it, and adds the
// window-B back-to-back write stall. Assumes addr is stable while rd/wr
// are high and that rd and wr are not both high.
module bus_wait_gen
    import ws_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   addr,
    input  logic            rd,
    input  logic            wr,
    input  logic            ext_rdy,
    input  logic [WS_W-1:0] fl_page_ws,
    input  logic [WS_W-1:0] fl_rand_ws,
    input  logic [WS_W-1:0] otp_ws,
    output logic            rdy,
    output logic [3:0]      region
);
    region_e        rg;
    logic           req, start, honour, hold_ok, b2b_wr;
    logic           perb_wr_done_q;
    logic [CW-1:0]  wcount;

    assign req     = rd | wr;
    assign honour  = (rg == RG_PERA) || (rg == RG_PERB);
    assign hold_ok = !honour || ext_rdy;
    assign b2b_wr  = perb_wr_done_q && wr && (rg == RG_PERB);
    assign region  = rg;

    ws_region_decode #(.ADDR_W(AW)) i_decode (
        .addr   (addr),
        .region (rg)
    );

    ws_count_select #(.ADDR_W(AW), .FW(WS_W), .CNT_W(CW), .PG_B(PAGE_BITS)) i_select (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .region  (rg),
        .is_wr   (wr),
        .b2b_wr  (b2b_wr),
        .addr    (addr),
        .page_ws (fl_page_ws),
        .rand_ws (fl_rand_ws),
        .otp_ws  (otp_ws),
        .wcount  (wcount)
    );

    ws_timer #(.CNT_W(CW)) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req),
        .wcount  (wcount),
        .hold_ok (hold_ok),
        .start   (start),
        .rdy     (rdy)
    );

    // Note a window-B write that completes this cycle, for the next one.
    always_ff @(posedge clk) begin
        if (!rst_n) perb_wr_done_q <= 1'b0;
        else        perb_wr_done_q <= rdy && wr && (rg == RG_PERB);
    end

    assert_rdy_needs_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rdy |-> (rd || wr));
    assert_hold_honoured_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy && (region == 4'd2 || region == 4'd3)) |-> ext_rdy);
    assert_b2b_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (perb_wr_done_q && start && wr && region == 4'd3) |-> !rdy);
endmodule

// File: tb/test_bus_wait_gen.sv
`timescale 1ns/1ps
module test_bus_wait_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic        rd = 1'b0, wr = 1'b0, ext_rdy = 1'b1;
    logic [3:0]  fl_page_ws = 4'd2, fl_rand_ws = 4'd5, otp_ws = 4'd3;
    logic        rdy;
    logic [3:0]  region;
    int          total = 0, bad = 0;
    int          w;
    logic [3:0]  rg;

    always #4 clk = ~clk;  // 125 MHz

    bus_wait_gen i_bus_wait_gen (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rd(rd), .wr(wr),
        .ext_rdy(ext_rdy), .fl_page_ws(fl_page_ws), .fl_rand_ws(fl_rand_ws),
        .otp_ws(otp_ws), .rdy(rdy), .region(region)
    );

    // Vector: addr[26:11], wr[10], ext_rdy[9], waits[8:4], region[3:0]
    localparam logic [26:0] VECS [0:16] = '{
        {16'h0100, 1'b0, 1'b1, 5'd0,  4'd1},  // R1 RAM read
        {16'h0F00, 1'b1, 1'b1, 5'd0,  4'd1},  // R1 RAM write
        {16'h1000, 1'b0, 1'b1, 5'd0,  4'd2},  // R2 window A
        {16'h2004, 1'b0, 1'b1, 5'd2,  4'd3},  // R3 window B read
        {16'h2008, 1'b1, 1'b1, 5'd0,  4'd3},  // R3 window B write
        {16'h3000, 1'b0, 1'b1, 5'd2,  4'd4},  // R3 window C read
        {16'h3010, 1'b1, 1'b1, 5'd0,  4'd4},  // R3 window C write
        {16'h4000, 1'b0, 1'b1, 5'd5,  4'd5},  // R6 first flash: random
        {16'h4006, 1'b0, 1'b1, 5'd2,  4'd5},  // R6 same page: paged
        {16'h4008, 1'b0, 1'b1, 5'd5,  4'd5},  // R6 new page: random
        {16'h6FFF, 1'b1, 1'b1, 5'd5,  4'd5},  // R6 new page write
        {16'h7FF0, 1'b0, 1'b1, 5'd16, 4'd6},  // R9 key window
        {16'h6FF8, 1'b0, 1'b1, 5'd2,  4'd5},  // R9 page kept across key access
        {16'h8000, 1'b0, 1'b1, 5'd3,  4'd7},  // R8 OTP
        {16'hF000, 1'b0, 1'b1, 5'd0,  4'd8},  // R1 boot ROM
        {16'hA000, 1'b0, 1'b1, 5'd0,  4'd0},  // R10 unmapped
        {16'h3004, 1'b0, 1'b0, 5'd2,  4'd4}   // R5 window C ignores hold-off
    };

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One access starting at the next falling edge; counts wait cycles.
    task automatic access(input logic [15:0] a, input logic is_wr, input logic ext,
                          output int waits, output logic [3:0] reg_o);
        @(negedge clk);
        addr = a; rd = !is_wr; wr = is_wr; ext_rdy = ext;
        waits = 0;
        #1 reg_o = region;
        while (!rdy && waits < 100) begin
            @(negedge clk);
            #1 waits++;
        end
    endtask

    task automatic idle();
        @(negedge clk);
        rd = 1'b0; wr = 1'b0; ext_rdy = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 chk("R11 rdy low in reset", int'(rdy), 0);
        @(negedge clk) rst_n = 1'b1;
        #1 chk("R11 rdy low after reset", int'(rdy), 0);

        for (int i = 0; i <= 16; i++) begin
            access(VECS[i][26:11], VECS[i][10], VECS[i][9], w, rg);
            chk($sformatf("R12 table waits vec %0d", i), w, int'(VECS[i][8:4]));
            chk($sformatf("R10 table region vec %0d", i), int'(rg), int'(VECS[i][3:0]));
            idle();
        end

        // R4: back-to-back window-B writes
        access(16'h2000, 1'b1, 1'b1, w, rg); chk("R4 first write", w, 0);
        access(16'h2002, 1'b1, 1'b1, w, rg); chk("R4 second write stalls", w, 1);
        access(16'h2004, 1'b1, 1'b1, w, rg); chk("R4 third write stalls", w, 1);
        access(16'h2006, 1'b0, 1'b1, w, rg); chk("R4 read after write no stall", w, 2);
        idle();
        access(16'h2006, 1'b1, 1'b1, w, rg); chk("R4 write after gap", w, 0);
        idle();
        access(16'h2008, 1'b1, 1'b1, w, rg); chk("R4 write after idle gap", w, 0);
        idle();

        // R2: window A held off by ext_rdy low
        @(negedge clk);
        addr = 16'h1040; rd = 1'b1; wr = 1'b0; ext_rdy = 1'b0;
        #1 chk("R2 held cycle 1", int'(rdy), 0);
        repeat (2) begin
            @(negedge clk);
            #1 chk("R2 held later cycle", int'(rdy), 0);
        end
        @(negedge clk) ext_rdy = 1'b1;
        #1 chk("R2 released", int'(rdy), 1);
        idle();

        // R7: clamping of the flash fields
        @(negedge clk); fl_page_ws = 4'd0; fl_rand_ws = 4'd0;
        access(16'h5000, 1'b0, 1'b1, w, rg); chk("R7 random floor 1", w, 1);
        idle();
        @(negedge clk); fl_page_ws = 4'd3; fl_rand_ws = 4'd1;
        access(16'h5100, 1'b0, 1'b1, w, rg); chk("R7 random raised to paged", w, 3);
        idle();
        @(negedge clk); fl_page_ws = 4'd1; fl_rand_ws = 4'd6;
        access(16'h5106, 1'b0, 1'b1, w, rg); chk("R6 paged hit", w, 1);
        idle();
        access(16'h7FF7, 1'b0, 1'b1, w, rg); chk("R9 key fixed", w, 16);
        idle();

        // R8: OTP clamp
        @(negedge clk); otp_ws = 4'd0;
        access(16'h8123, 1'b0, 1'b1, w, rg); chk("R8 otp floor", w, 1);
        idle();
        @(negedge clk); otp_ws = 4'd9;
        access(16'h8FFF, 1'b1, 1'b1, w, rg); chk("R8 otp programmed", w, 9);
        idle();

        // R11: no strobe, no ready
        repeat (3) begin
            @(negedge clk); addr = 16'h0000; ext_rdy = 1'b1;
            #1 chk("R11 idle rdy low", int'(rdy), 0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 8);
        total++; bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule